// File: doc/BRIEF.md
# Divider-Clocked Programmable Timer

This block is a free-running divider with an 8-bit programmable counter on top of it. The divider advances by one on every system clock. A control field picks one divider bit and gates it with an enable. The counter steps once each time that gated bit drops from 1 to 0. Because the counter looks for a falling edge and does not count clock periods, any event that pulls the gated bit low also steps the counter. Clearing the divider, disabling the timer or moving the tap to a bit that is low all count as such events.

When the counter passes its maximum, it takes a new start value from a reload register and raises a one-cycle interrupt request. The same divider also produces a one-cycle strobe for a sound frame sequencer. The strobe follows a falling edge of a high divider bit, and a speed-mode input chooses which bit. Software reaches the divider view, the counter, the reload value and the control field through a small register bus with a combinational read port.

Top module: `divtmr_top`

## Requirements
- R1: After reset the divider, counter, reload value and control field are all zero, the interrupt and strobe are low, and the control field reads as 0xF8.
- R2: The bus map is: address 0 is the divider view, 1 the counter, 2 the reload value and 3 the control field. The 16-bit divider advances by one per clock and wraps from 0xFFFF to 0. A read at address 0 returns divider bits 15:8.
- R3: A write of any data to address 0 sets the divider to zero at that clock edge. If this clearing makes the gated bit fall, the counter steps.
- R4: The gated bit is control bit 2 AND the divider bit picked by control bits 1:0 (00 picks bit 9, 01 bit 3, 10 bit 5, 11 bit 7). The counter steps by one at each edge where the gated bit goes from 1 to 0.
- R5: A control write compares the old setting on the old divider with the new setting on the new divider. It causes an extra step when the old setting was enabled with its bit at 1, and the new setting is either disabled or has its bit at 0.
- R6: A step from 0xFF loads the reload value into the counter and drives the interrupt request high for exactly one cycle.
- R7: The counter and reload value are written and read at addresses 1 and 2. A counter write wins over a step in the same cycle.
- R8: The sequencer strobe is a one-cycle pulse after divider bit 12 falls when the speed input is 0, or after bit 13 falls when it is 1.
- R9: The control field keeps the written bits 2:0. Bits 7:3 are ignored on write and read as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| fast_mode | input | 1 | Selects divider bit 13 instead of 12 for the sequencer strobe |
| tmr_irq | output | 1 | One-cycle counter overflow request |
| seq_strobe | output | 1 | One-cycle sound frame sequencer event |

## Verification
A divider that is off by even one count shows up at address 0 only when the fault reaches bit 8. Before that, it shows as a counter step or strobe that arrives one or more cycles off. The bench therefore compares the counter on every cycle and does not wait for the divider view. A wrong tap or a mishandled control write changes the counter value on the next cycle, and the bench reads that value back at once. A broken reload shows in the same cycle as the interrupt pulse, where the counter must already equal the reload value.

// File: rtl/divtmr_pkg.sv
package divtmr_pkg;

  typedef enum logic [1:0] {
    REG_DIV = 2'd0,
    REG_CNT = 2'd1,
    REG_RLD = 2'd2,
    REG_CTL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       en;
    logic [1:0] rate;
  } ctl_t;

  localparam int CTL_W = 3;
  localparam int N_TAPS = 4;

endpackage

// File: rtl/divtmr_divider.sv
module divtmr_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] div_nx
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  always_comb begin
    if (clr) div_nx = '0;
    else     div_nx = div_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_nx;
  end

endmodule

// File: rtl/divtmr_fall_sel.sv
module divtmr_fall_sel
  import divtmr_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int TAP0         = 9,
  parameter int TAP1         = 3,
  parameter int TAP2         = 5,
  parameter int TAP3         = 7,
  parameter int SEQ_NORM_BIT = 12,
  parameter int SEQ_FAST_BIT = 13
) (
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_nx,
  input  ctl_t             ctl_q,
  input  ctl_t             ctl_nx,
  input  logic             fast_mode,
  output logic             tmr_fall,
  output logic             seq_fall
);

  logic [N_TAPS-1:0] tap_now;
  logic [N_TAPS-1:0] tap_nxt;
  logic              gate_now;
  logic              gate_nxt;
  logic              seq_now;
  logic              seq_nxt;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int BIT = (g == 0) ? TAP0 : (g == 1) ? TAP1 : (g == 2) ? TAP2 : TAP3;
    assign tap_now[g] = div_q[BIT];
    assign tap_nxt[g] = div_nx[BIT];
  end

  always_comb begin
    gate_now = ctl_q.en  & tap_now[ctl_q.rate];
    gate_nxt = ctl_nx.en & tap_nxt[ctl_nx.rate];
    tmr_fall = gate_now & ~gate_nxt;
  end

  always_comb begin
    if (fast_mode) begin
      seq_now = div_q[SEQ_FAST_BIT];
      seq_nxt = div_nx[SEQ_FAST_BIT];
    end else begin
      seq_now = div_q[SEQ_NORM_BIT];
      seq_nxt = div_nx[SEQ_NORM_BIT];
    end
    seq_fall = seq_now & ~seq_nxt;
  end

endmodule

// File: rtl/divtmr_counter.sv
module divtmr_counter
  import divtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic             wr_ctl,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tmr_fall,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output ctl_t             ctl_q,
  output ctl_t             ctl_nx,
  output logic             irq_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_nx;
  logic             cnt_en;
  logic             ovf;

  always_comb begin
    ctl_nx = wr_ctl ? ctl_t'(wdata[CTL_W-1:0]) : ctl_q;
  end

  always_comb begin
    ovf    = 1'b0;
    cnt_en = wr_cnt | tmr_fall;
    cnt_nx = cnt_q;
    if (wr_cnt) begin
      cnt_nx = wdata;
    end else if (tmr_fall) begin
      if (&cnt_q) begin
        cnt_nx = rld_q;
        ovf    = 1'b1;
      end else begin
        cnt_nx = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_nx;
      if (wr_rld) rld_q <= wdata;
      if (wr_ctl) ctl_q <= ctl_nx;
      irq_q <= ovf;
    end
  end

endmodule

// File: rtl/divtmr_top.sv
module divtmr_top
  import divtmr_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int CNT_W        = 8,
  parameter int TAP0         = 9,
  parameter int TAP1         = 3,
  parameter int TAP2         = 5,
  parameter int TAP3         = 7,
  parameter int SEQ_NORM_BIT = 12,
  parameter int SEQ_FAST_BIT = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             fast_mode,
  output logic             tmr_irq,
  output logic             seq_strobe
);

  localparam int PAD_W = CNT_W - CTL_W;

  logic             rst_meta;
  logic             rst_sync_n;
  logic             wr_div;
  logic             wr_cnt;
  logic             wr_rld;
  logic             wr_ctl;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;
  ctl_t             ctl_q;
  ctl_t             ctl_nx;
  logic             tmr_fall;
  logic             seq_fall;
  logic             strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    wr_div = bus_wr && (bus_addr == REG_DIV);
    wr_cnt = bus_wr && (bus_addr == REG_CNT);
    wr_rld = bus_wr && (bus_addr == REG_RLD);
    wr_ctl = bus_wr && (bus_addr == REG_CTL);
  end

  divtmr_divider #(.DIV_W(DIV_W)) div_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (wr_div),
    .div_q  (div_q),
    .div_nx (div_nx)
  );

  divtmr_fall_sel #(
    .DIV_W        (DIV_W),
    .TAP0         (TAP0),
    .TAP1         (TAP1),
    .TAP2         (TAP2),
    .TAP3         (TAP3),
    .SEQ_NORM_BIT (SEQ_NORM_BIT),
    .SEQ_FAST_BIT (SEQ_FAST_BIT)
  ) fall_i (
    .div_q     (div_q),
    .div_nx    (div_nx),
    .ctl_q     (ctl_q),
    .ctl_nx    (ctl_nx),
    .fast_mode (fast_mode),
    .tmr_fall  (tmr_fall),
    .seq_fall  (seq_fall)
  );

  divtmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_cnt   (wr_cnt),
    .wr_rld   (wr_rld),
    .wr_ctl   (wr_ctl),
    .wdata    (bus_wdata),
    .tmr_fall (tmr_fall),
    .cnt_q    (cnt_q),
    .rld_q    (rld_q),
    .ctl_q    (ctl_q),
    .ctl_nx   (ctl_nx),
    .irq_q    (tmr_irq)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) strobe_q <= 1'b0;
    else             strobe_q <= seq_fall;
  end
  assign seq_strobe = strobe_q;

  always_comb begin
    unique case (bus_addr)
      REG_DIV: bus_rdata = div_q[DIV_W-1 -: CNT_W];
      REG_CNT: bus_rdata = cnt_q;
      REG_RLD: bus_rdata = rld_q;
      default: bus_rdata = {{PAD_W{1'b1}}, ctl_q};
    endcase
  end

endmodule

// File: rtl/divtmr_chk.sv
module divtmr_chk #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] bus_rdata,
  input logic [DIV_W-1:0] div_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rld_q,
  input logic             tmr_irq,
  input logic             seq_strobe
);

  AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr && bus_addr == 2'd0) |=> div_q == DIV_W'($past(div_q) + 1'b1)); // R2

  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == 2'd0) |=> div_q == '0); // R3

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_irq |=> !tmr_irq); // R6

  AST_IRQ_RELOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_irq |-> cnt_q == $past(rld_q)); // R6

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == 2'd1) |=> cnt_q == $past(bus_wdata)); // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seq_strobe |=> !seq_strobe); // R8

  AST_CTL_PAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_addr == 2'd3 |-> &bus_rdata[CNT_W-1:3]); // R9

endmodule

bind divtmr_top divtmr_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .div_q      (div_q),
  .cnt_q      (cnt_q),
  .rld_q      (rld_q),
  .tmr_irq    (tmr_irq),
  .seq_strobe (seq_strobe)
);

// File: tb/divtmr_top_tb_top.sv
`timescale 1ns/1ps
module divtmr_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       fast_mode;
  logic       tmr_irq;
  logic       seq_strobe;

  always #2.5 clk = ~clk;

  divtmr_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .fast_mode  (fast_mode),
    .tmr_irq    (tmr_irq),
    .seq_strobe (seq_strobe)
  );

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  logic [15:0] m_div;
  logic [7:0]  m_cnt;
  logic [7:0]  m_rld;
  logic [2:0]  m_ctl;
  logic        m_irq;
  logic        m_stb;

  function automatic int tap_of(input logic [1:0] r);
    case (r)
      2'd0:    return 9;
      2'd1:    return 3;
      2'd2:    return 5;
      default: return 7;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_div[15:8];
      2'd1:    return m_cnt;
      2'd2:    return m_rld;
      default: return {5'h1f, m_ctl};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0:    return "R2 divider view";
      2'd1:    return "R4 counter";
      2'd2:    return "R7 reload";
      default: return "R9 control";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, advance the model, compare at next negedge.
  task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d);
    logic [15:0] ndiv;
    logic [2:0]  nctl;
    logic        g_old, g_new, inc;
    int          sb;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    ndiv  = (w && a == 2'd0) ? 16'h0 : m_div + 16'h1;
    nctl  = (w && a == 2'd3) ? d[2:0] : m_ctl;
    g_old = m_ctl[2] & m_div[tap_of(m_ctl[1:0])];
    g_new = nctl[2] & ndiv[tap_of(nctl[1:0])];
    inc   = g_old & ~g_new;
    sb    = fast_mode ? 13 : 12;
    m_stb = m_div[sb] & ~ndiv[sb];
    m_irq = 1'b0;
    if (w && a == 2'd1) m_cnt = d;
    else if (inc) begin
      if (m_cnt == 8'hff) begin m_cnt = m_rld; m_irq = 1'b1; end
      else m_cnt = m_cnt + 8'h1;
    end
    if (w && a == 2'd2) m_rld = d;
    m_ctl = nctl;
    m_div = ndiv;
    @(negedge clk);
    check("R6 interrupt", {7'h0, tmr_irq}, {7'h0, m_irq});
    check("R8 strobe", {7'h0, seq_strobe}, {7'h0, m_stb});
    check(tag_of(a), bus_rdata, exp_read(a));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] c0;
    int         hits;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h0; fast_mode = 1'b0;
    m_div = '0; m_cnt = '0; m_rld = '0; m_ctl = '0; m_irq = 1'b0; m_stb = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state through the read port
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); #0.5;
      check("R1 reset read", bus_rdata, (a == 3) ? 8'hf8 : 8'h00);
    end
    check("R1 reset irq", {7'h0, tmr_irq}, 8'h0);
    check("R1 reset strobe", {7'h0, seq_strobe}, 8'h0);
    bus_addr = 2'd0;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 divider held during reset release", bus_rdata, 8'h00);

    // R4 rate 01 (bit 3) stepping
    step(1'b1, 2'd3, 8'h05);
    for (int i = 0; i < 64; i++) step(1'b0, 2'd1, 8'h0);

    // R3 divider clear makes bit 9 fall
    step(1'b1, 2'd3, 8'h04);
    while (!m_div[9]) step(1'b0, 2'd1, 8'h0);
    c0 = m_cnt;
    step(1'b1, 2'd0, 8'ha5);
    step(1'b0, 2'd1, 8'h0);
    check("R3 clear with bit 9 high steps counter", bus_rdata, c0 + 8'h1);

    // R5 control write moving tap to a low bit
    step(1'b1, 2'd3, 8'h05);
    while (!(m_div[3] && m_div[2:0] != 3'h7)) step(1'b0, 2'd1, 8'h0);
    c0 = m_cnt;
    step(1'b1, 2'd3, 8'h04);
    step(1'b0, 2'd1, 8'h0);
    check("R5 tap change to low bit steps counter", bus_rdata, c0 + 8'h1);
    // R5 control write disabling while bit high
    step(1'b1, 2'd3, 8'h05);
    while (!(m_div[3] && m_div[2:0] != 3'h7)) step(1'b0, 2'd1, 8'h0);
    c0 = m_cnt;
    step(1'b1, 2'd3, 8'h01);
    step(1'b0, 2'd1, 8'h0);
    check("R5 disable with bit high steps counter", bus_rdata, c0 + 8'h1);

    // R6 overflow reload
    step(1'b1, 2'd2, 8'hc3);
    step(1'b1, 2'd1, 8'hfe);
    step(1'b1, 2'd3, 8'h05);
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 2'd1, 8'h0);
      if (tmr_irq) begin
        hits++;
        check("R6 reload value on overflow", bus_rdata, 8'hc3);
      end
    end
    check("R6 exactly one interrupt", 8'(hits), 8'd1);

    // R7 counter write wins over a same-cycle step
    while (m_div[3:0] != 4'hf) step(1'b0, 2'd1, 8'h0);
    step(1'b1, 2'd1, 8'h42);
    step(1'b0, 2'd1, 8'h0);
    check("R7 write beats step", bus_rdata, 8'h42);

    // R9 upper control bits ignored
    step(1'b1, 2'd3, 8'h02);
    check("R9 control readback", bus_rdata, 8'hfa);

    // R8 strobe spacing in both speeds
    step(1'b1, 2'd0, 8'h00);
    hits = 0;
    for (int i = 0; i < 8200; i++) begin
      step(1'b0, 2'd0, 8'h0);
      if (seq_strobe) hits++;
    end
    check("R8 one strobe per 8192 in normal speed", 8'(hits), 8'd1);
    fast_mode = 1'b1;
    step(1'b1, 2'd0, 8'h00);
    hits = 0;
    for (int i = 0; i < 16390; i++) begin
      step(1'b0, 2'd0, 8'h0);
      if (seq_strobe) hits++;
    end
    check("R8 one strobe per 16384 in fast speed", 8'(hits), 8'd1);
    fast_mode = 1'b0;

    // R2 wrap from 0xFFFF
    while (m_div != 16'hffff) step(1'b0, 2'd0, 8'h0);
    step(1'b0, 2'd0, 8'h0);
    check("R2 divider wrap", bus_rdata, 8'h00);

    // Constrained random mix
    for (int i = 0; i < 40000; i++) begin
      int unsigned r;
      logic [1:0]  ra;
      logic [7:0]  rd;
      r  = $urandom % 4000;
      ra = 2'($urandom % 4);
      rd = 8'($urandom);
      if (r == 0) fast_mode = ~fast_mode;
      if (r == 1) step(1'b1, 2'd0, rd);
      else if (r < 40) step(1'b1, 2'd1, rd | 8'hf0);
      else if (r < 60) step(1'b1, 2'd2, rd);
      else if (r < 100) step(1'b1, 2'd3, rd);
      else step(1'b0, ra, 8'h0);
    end

    finish_run();
  end

endmodule